// File: doc/BRIEF.md
# MDIO Single-Command Transaction Engine

This block runs one management-bus transaction to an Ethernet PHY at a time. Software loads a data register (for writes) and then a command register. The command register holds the direction, the two programmable low bits of the PHY address, the 5-bit register number and a start bit. Once the start bit is set, the engine waits for the next falling-edge strobe from an external MDC divider. It then shifts a 64-bit clause-22 frame out on the MDIO pins.

On a read, the engine stops driving the line after the address fields. It samples the 16 reply bits and places them in the data register. In that same cycle the start bit drops back to zero, so software only needs to poll that bit. The engine does not generate MDC itself. It is paced by single-cycle `mdcRise` and `mdcFall` strobes from a separate clock generator.

Top module: `mdioCmdEngine`

## Requirements
- R1: After reset both registers read as zero, and `mdioOe` is low whenever no transaction is in progress.
- R2: Reading the command register (`regAddr`=0) returns the busy/start flag in bit 15, the write flag in bit 14, the PHY low address in bits 9:8 and the register number in bits 4:0. All other bits read zero.
- R3: A write sends 64 bits MSB first, one bit per MDC period: 32 ones, then 01, then opcode 01, then the 5-bit PHY address, then the register number, then turnaround 10, then the data register value.
- R4: A read sends the same first 46 bits with opcode 10. It then releases `mdioOe` for the 2 turnaround bits and the 16 data bits.
- R5: On a read, the 16 data bits are sampled from `mdioIn` on rise strobes, MSB first, and stored in the data register (`regAddr`=1).
- R6: The start flag reads 1 from the cycle after the start write until completion. It then clears by itself on the cycle after the rise strobe of the 64th bit.
- R7: Read data appears in the data register in the same cycle the start flag clears. A write transaction leaves the data register unchanged.
- R8: `mdioOut` and `mdioOe` change only in the cycle after a fall strobe, except at completion.
- R9: A command-register write issued while a transaction is in progress is ignored entirely. This covers both its start bit and its fields.
- R10: The upper three PHY address bits are always sent as zero, whatever the command bits 13:10 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = command register, 1 = data register |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read view of the register selected by `regAddr` |
| mdcRise | input | 1 | One-cycle strobe marking an MDC rising edge |
| mdcFall | input | 1 | One-cycle strobe marking an MDC falling edge |
| mdioIn | input | 1 | MDIO line input |
| mdioOut | output | 1 | MDIO line output value |
| mdioOe | output | 1 | MDIO output enable |

## Verification
Each frame bit appears on `mdioOut` one cycle after the fall strobe that starts it. The PHY model in the bench therefore latches the line in the cycle just before each rise strobe, when the bit is settled. Read bits are presented by the model in the cycle after each fall strobe and are sampled by the engine at the following rise strobe. The start flag clears, and read data lands, one cycle after the final rise strobe. The bench polls the flag at falling clock edges and switches to the data register in that same cycle. Every command readback is taken a fixed delay after the register write, away from the active edge.

// File: rtl/mdioPkg.sv
package mdioPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;  // start request taken
    logic load;    // build frame into shifter
    logic shift;   // advance to next frame bit
    logic sample;  // capture one read bit
    logic finish;  // last bit done
  } engStrobe_t;
endpackage

// File: rtl/mdioCtrl.sv
module mdioCtrl
  import mdioPkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int TA_IDX    = 46
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       mdcRise,
  input  logic       mdcFall,
  input  logic       isWrite,
  output engStrobe_t strb,
  output logic       busy,
  output logic       driveEn
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_POS     = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] DATA_START = IDX_W'(TA_IDX + 2);

  engState_t         state;
  logic [IDX_W-1:0]  bitIdx;

  always_comb begin
    strb        = '0;
    strb.accept = (state == ST_IDLE) && startReq;
    strb.load   = (state == ST_ARM) && mdcFall;
    strb.shift  = (state == ST_RUN) && mdcFall;
    strb.sample = (state == ST_RUN) && mdcRise && !isWrite && (bitIdx >= DATA_START);
    strb.finish = (state == ST_RUN) && mdcRise && (bitIdx == LAST_IDX);
  end

  assign busy    = (state != ST_IDLE);
  assign driveEn = (state == ST_RUN) && (isWrite || (bitIdx < TA_POS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (strb.accept) state <= ST_ARM;
        ST_ARM: if (strb.load) begin
          state  <= ST_RUN;
          bitIdx <= '0;
        end
        ST_RUN: begin
          if (strb.finish) state <= ST_IDLE;
          else if (strb.shift) bitIdx <= bitIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdioDatapath.sv
module mdioDatapath
  import mdioPkg::*;
#(
  parameter int PRE_BITS  = 32,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int PHY_PROG  = 2,
  parameter int FRAME_LEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        strb,
  input  logic              busy,
  input  logic              driveEn,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              mdioIn,
  output logic [DATA_W-1:0] regRdData,
  output logic              cmdWrite,
  output logic [DATA_W-1:0] dataQ,
  output logic              mdioOut,
  output logic              mdioOe
);
  localparam int BIT_START = 15;
  localparam int BIT_WRITE = 14;
  localparam int PHY_POS   = 8;

  logic [PHY_PROG-1:0]  phyLo;
  logic [ADDR_W-1:0]    regNum;
  logic [FRAME_LEN-1:0] frameSh;
  logic [DATA_W-1:0]    rdSh;
  logic [ADDR_W-1:0]    phyFull;
  logic [FRAME_LEN-1:0] frameNext;
  logic                 cmdLoad;
  logic [DATA_W-1:0]    rdWord;

  assign cmdLoad = regWrEn && !regAddr && !busy;
  assign phyFull = {{(ADDR_W-PHY_PROG){1'b0}}, phyLo};
  assign frameNext = {{PRE_BITS{1'b1}}, 2'b01,
                      (cmdWrite ? 2'b01 : 2'b10),
                      phyFull, regNum,
                      (cmdWrite ? 2'b10 : 2'b00),
                      (cmdWrite ? dataQ : {DATA_W{1'b0}})};
  assign rdWord = {rdSh[DATA_W-2:0], mdioIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWrite <= 1'b0;
      phyLo    <= '0;
      regNum   <= '0;
      dataQ    <= '0;
      frameSh  <= '0;
      rdSh     <= '0;
    end else begin
      if (cmdLoad) begin
        cmdWrite <= regWrData[BIT_WRITE];
        phyLo    <= regWrData[PHY_POS +: PHY_PROG];
        regNum   <= regWrData[ADDR_W-1:0];
      end
      if (strb.load)       frameSh <= frameNext;
      else if (strb.shift) frameSh <= {frameSh[FRAME_LEN-2:0], 1'b0};
      if (strb.sample)     rdSh <= rdWord;
      if (strb.finish && !cmdWrite) dataQ <= rdWord;
      else if (regWrEn && regAddr)  dataQ <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr) begin
      regRdData = dataQ;
    end else begin
      regRdData[BIT_START]               = busy;
      regRdData[BIT_WRITE]               = cmdWrite;
      regRdData[PHY_POS +: PHY_PROG]     = phyLo;
      regRdData[ADDR_W-1:0]              = regNum;
    end
  end

  assign mdioOut = driveEn & frameSh[FRAME_LEN-1];
  assign mdioOe  = driveEn;
endmodule

// File: rtl/mdioCmdEngine.sv
module mdioCmdEngine
  import mdioPkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int PHY_PROG = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              mdcRise,
  input  logic              mdcFall,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe
);
  localparam int TA_IDX    = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int FRAME_LEN = TA_IDX + 2 + DATA_W;

  engStrobe_t        strb;
  logic              busy;
  logic              driveEn;
  logic              cmdWrite;
  logic [DATA_W-1:0] dataQ;
  logic              startReq;

  assign startReq = regWrEn && !regAddr && regWrData[DATA_W-1];

  mdioCtrl #(.FRAME_LEN(FRAME_LEN), .TA_IDX(TA_IDX)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .mdcRise(mdcRise), .mdcFall(mdcFall), .isWrite(cmdWrite),
    .strb(strb), .busy(busy), .driveEn(driveEn)
  );

  mdioDatapath #(.PRE_BITS(PRE_BITS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                 .PHY_PROG(PHY_PROG), .FRAME_LEN(FRAME_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .driveEn(driveEn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .mdioIn(mdioIn), .regRdData(regRdData), .cmdWrite(cmdWrite),
    .dataQ(dataQ), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: rtl/mdioCmdEngineChk.sv
module mdioCmdEngineChk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regAddr,
  input logic              regWrStart,
  input logic              mdcRise,
  input logic              mdcFall,
  input logic              busy,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic [DATA_W-1:0] dataQ
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);

  assert_out_on_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(mdcFall)) |-> ($stable(mdioOut) && $stable(mdioOe)));

  assert_start_by_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWrEn && !regAddr && regWrStart));

  assert_clear_on_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(mdcRise));

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(regWrEn && regAddr) && !$fell(busy)) |-> $stable(dataQ));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && !regAddr && !mdcRise) |=> busy);
endmodule

bind mdioCmdEngine mdioCmdEngineChk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrStart(regWrData[DATA_W-1]), .mdcRise(mdcRise), .mdcFall(mdcFall),
  .busy(busy), .mdioOut(mdioOut), .mdioOe(mdioOe), .dataQ(dataQ)
);

// File: tb/tb_mdioCmdEngine.sv
module tb_mdioCmdEngine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        mdcRise = 1'b0;
  logic        mdcFall = 1'b0;
  logic        mdioIn = 1'b0;
  logic        mdioOut;
  logic        mdioOe;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // PHY model state
  bit          mdcRun = 0;
  int          mdcCnt = 0;
  int          nf = 0;
  int          capN = 0;
  int          viol = 0;
  logic [63:0] cap = '0;
  logic [15:0] rdPat = '0;
  logic        oeLast = 1'b0;
  logic        outLast = 1'b0;

  // {write, phyLo[1:0], regNum[4:0], data/pattern[15:0]}
  localparam logic [23:0] VEC [5] = '{
    {1'b1, 2'b11, 5'h1F, 16'hA5C3},
    {1'b0, 2'b01, 5'h02, 16'h3C96},
    {1'b1, 2'b00, 5'h00, 16'h0001},
    {1'b0, 2'b10, 5'h11, 16'h8001},
    {1'b0, 2'b11, 5'h0A, 16'hFFFF}
  };

  mdioCmdEngine dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdcRise(mdcRise),
    .mdcFall(mdcFall), .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  always #4 clk = ~clk;

  // MDC strobe source (divide by 7) and PHY model, all away from the active edge
  always @(negedge clk) begin
    if (mdcOeChange()) viol++;
    if (mdcFall) begin
      if (!mdioOe) begin
        nf++;
        mdioIn = (nf >= 3 && nf <= 18) ? rdPat[18 - nf] : 1'b0;
      end else begin
        nf = 0;
      end
    end
    oeLast  = mdioOe;
    outLast = mdioOut;
    if (mdcRun) begin
      mdcCnt  = (mdcCnt == 6) ? 0 : mdcCnt + 1;
      mdcRise = (mdcCnt == 0);
      mdcFall = (mdcCnt == 3);
    end
    if (mdcRise && mdioOe) begin
      cap = {cap[62:0], mdioOut};
      capN++;
    end
  end

  // R8: a change on the line without a preceding fall strobe (completion excluded)
  function automatic bit mdcOeChange();
    if (mdcFall || mdcRise) return 0;
    return (mdioOe != oeLast) || (mdioOe && oeLast && mdioOut != outLast);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic runTxn(input logic [23:0] v, input logic [15:0] junk, input bit intrude);
    logic        wr;
    logic [1:0]  phy;
    logic [4:0]  rn;
    logic [15:0] d;
    logic [15:0] cmd;
    logic [63:0] expF;
    logic [15:0] prevData;
    logic [15:0] got;
    bit          cleared;
    {wr, phy, rn, d} = v;
    if (wr) regWrite(1'b1, d);
    regAddr = 1'b1; #1 prevData = regRdData;
    rdPat = d; cap = '0; capN = 0; nf = 0;
    cmd = {1'b1, wr, 4'b0, phy, 3'b0, rn} | junk;
    regWrite(1'b0, cmd);
    regAddr = 1'b0; #1;
    check(regRdData[15] == 1'b1, "R6 start flag set while busy", {48'b0, regRdData}, 64'h8000);
    if (intrude) begin
      repeat (100) @(negedge clk);
      regWrite(1'b0, 16'hC000 | {8'b0, 3'b0, ~rn});
      regWrite(1'b0, 16'h0000);
      regAddr = 1'b0; #1;
      check(regRdData == ({1'b1, wr, 4'b0, phy, 3'b0, rn}), "R9 command fields unchanged while busy",
            {48'b0, regRdData}, {48'b0, 1'b1, wr, 4'b0, phy, 3'b0, rn});
    end
    cleared = 0;
    for (int i = 0; i < 3000 && !cleared; i++) begin
      @(negedge clk);
      regAddr = 1'b0; #1;
      if (!regRdData[15]) begin
        cleared = 1;
        regAddr = 1'b1; #1 got = regRdData;
      end
    end
    check(cleared, "R6 start flag clears by itself", {63'b0, cleared}, 64'h1);
    expF = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), 3'b000, phy, rn,
            (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
    if (wr) begin
      check(capN == 64, "R3 write drives 64 bits", capN, 64);
      check(cap == expF, "R3 R10 write frame content", cap, expF);
      check(got == prevData, "R7 write leaves data register", {48'b0, got}, {48'b0, prevData});
    end else begin
      check(capN == 46, "R4 read drives 46 bits then releases", capN, 46);
      check(cap[45:0] == expF[63:18], "R4 R10 read header content", {18'b0, cap[45:0]}, {18'b0, expF[63:18]});
      check(got == d, "R5 R7 read data present when flag clears", {48'b0, got}, {48'b0, d});
    end
    @(negedge clk);
    check(!mdioOe, "R1 line released after completion", {63'b0, mdioOe}, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regAddr = 1'b0; #1;
    check(regRdData == 16'h0, "R1 command register after reset", {48'b0, regRdData}, 64'h0);
    regAddr = 1'b1; #1;
    check(regRdData == 16'h0, "R1 data register after reset", {48'b0, regRdData}, 64'h0);
    check(!mdioOe, "R1 output enable low after reset", {63'b0, mdioOe}, 64'h0);
    mdcRun = 1;
    // R2 field readback without start
    regWrite(1'b0, 16'h7FFF);
    regAddr = 1'b0; #1;
    check(regRdData == 16'h431F, "R2 command readback fields", {48'b0, regRdData}, 64'h431F);
    regWrite(1'b1, 16'h1234);
    regAddr = 1'b1; #1;
    check(regRdData == 16'h1234, "R2 data register readback", {48'b0, regRdData}, 64'h1234);
    // vector walk
    for (int k = 0; k < 5; k++) runTxn(VEC[k], 16'h0000, 1'b0);
    // R10 junk in upper command bits, R9 intrusion during a write and a read
    runTxn({1'b1, 2'b10, 5'h15, 16'h5AA5}, 16'h3CE0, 1'b0);
    runTxn({1'b1, 2'b01, 5'h07, 16'hC0DE}, 16'h0000, 1'b1);
    runTxn({1'b0, 2'b11, 5'h1E, 16'h6B29}, 16'h0000, 1'b1);
    check(viol == 0, "R8 line changes only after fall strobes", viol, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule